// File: doc/BRIEF.md
# Hex-Mesh Broadcast Forwarding Out-Queue

This block is the outgoing packet queue of one node in a hexagonal-mesh array of processing nodes. The node pushes a packet with a store-word operation. Each packet carries four things:

- the ID of the node that originated it,
- a 3-bit code for the direction it arrived on,
- a detour bit,
- a payload word.

Packets leave the queue in arrival order. For the packet at the head, a routing decoder works out which of the six neighbour links must receive it, and which detour bit goes out on each link. The decoder uses the arrival direction, the detour bit and two border-position inputs.

The block raises a send request on every link the head packet still owes. A link counts as served when its acknowledge arrives while its request is high. Links already served are never requested again for that packet, so no neighbour gets a duplicate. The entry is released in the same cycle as the acknowledge that completes its last outstanding link. A clear command empties the queue at once.

Top module: `hexfwd_outbuf`

## Requirements
- R1: Bit k of `send_req`, `send_detour` and `send_ack` stands for direction code k+1. Direction codes are 3 bits. Code 0 means the packet arrived from the layer below. A packet with code 0 is requested on all six links with every detour bit 0, whatever its detour bit.
- R2: With the detour bit clear, arrival codes 1 to 3 route as follows:
  - Code 1 goes to link 1 (detour 0). It also goes to link 6 (detour 0) when either border input is 1.
  - Code 2 goes to links 1, 2 and 3. The detour bit is 1 on links 1 and 3 and 0 on link 2.
  - Code 3 goes to links 3 (detour 0) and 4 (detour 1).
- R3: With the detour bit clear, arrival codes 4 to 6 route as follows:
  - Code 4 goes to link 4 (detour 0). It also goes to link 3 (detour 0) when either border input is 1.
  - Code 5 goes to links 4, 5 and 6. The detour bit is 1 on links 4 and 6 and 0 on link 5.
  - Code 6 goes to links 6 (detour 0) and 1 (detour 1).
- R4: With the detour bit set, a packet with arrival code 1 to 6 goes only to the link of its own code, with detour 1. The exceptions in R5 take precedence.
- R5: Two exceptions apply when the detour bit is set:
  - Code 4 at an upper-border node (`upper_border`=1) goes only to link 3, with detour 0.
  - Code 1 at a lower-border node (`lower_border`=1) goes to links 1, 3, 4 and 6. Link 1 carries detour 1 and the others carry detour 0.
- R6: A packet with arrival code 7 requests no link and is discarded when it reaches the head.
- R7: Packets are served in push order. A push is accepted only when `full` is 0. A push while full has no effect on the stored packets.
- R8: After reset, `empty`=1, `full`=0 and no request is raised. `full` is 1 exactly when DEPTH packets are held. `empty` is 1 exactly when none are held.
- R9: `clear_q` empties the queue in the next cycle and wins over a push in the same cycle. A cleared packet raises no further request.
- R10: Requests are raised only while the queue holds a packet, and only on links the head packet still owes. An acknowledge on a link whose request is low is ignored.
- R11: The head packet is removed at the clock edge that carries the acknowledge completing its last owed link. The requests of the next packet appear in the following cycle.
- R12: `pending` is 1 exactly when the head packet still owes at least one link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Store-word push strobe |
| push_origin | input | ID_W | Originating node ID of pushed packet |
| push_dir | input | 3 | Arrival direction code of pushed packet |
| push_detour | input | 1 | Detour bit of pushed packet |
| push_data | input | DATA_W | Payload word of pushed packet |
| clear_q | input | 1 | Empty the queue |
| upper_border | input | 1 | Node sits on the upper border |
| lower_border | input | 1 | Node sits on the lower border |
| send_ack | input | 6 | Per-link delivery acknowledge |
| full | output | 1 | Queue holds DEPTH packets |
| empty | output | 1 | Queue holds no packet |
| send_req | output | 6 | Per-link send request for head packet |
| send_detour | output | 6 | Detour bit to send on each link |
| send_origin | output | ID_W | Originating node ID of head packet |
| send_data | output | DATA_W | Payload word of head packet |
| pending | output | 1 | Head packet still owes a link |

## Verification
The bench goes after the border-dependent routing cases and the detour-set exceptions. A decoder that mixes up the two borders would send a detoured code-4 packet on link 4 instead of link 3, or would drop the four-way fan-out of a detoured code-1 packet. Random acknowledges arrive on links with no request and on links already served. A tracker that counted those would release an entry early or request a link twice. Pushes while full and a clear that coincides with a push are driven on purpose. A wrong pointer wrap would reorder packets or lose them, and a clear that loses to a push would leave a stale packet raising requests. Code-7 packets check that an entry owing nothing is released at once instead of blocking the queue.

// File: rtl/hexfwd_pkg.sv
package hexfwd_pkg;

    localparam int NDIR = 6;

    typedef enum logic [2:0] {
        DIR_BELOW = 3'd0,
        DIR_NW    = 3'd1,
        DIR_N     = 3'd2,
        DIR_NE    = 3'd3,
        DIR_SE    = 3'd4,
        DIR_S     = 3'd5,
        DIR_SW    = 3'd6,
        DIR_BAD   = 3'd7
    } dir_e;

    typedef struct packed {
        logic [NDIR-1:0] links;
        logic [NDIR-1:0] detour;
    } fanout_t;

    // add one outgoing link (code 1..6) with the given detour bit
    function automatic fanout_t add_link(fanout_t f, int code, logic det);
        fanout_t r;
        r = f;
        r.links[code-1]  = 1'b1;
        r.detour[code-1] = det;
        return r;
    endfunction

    function automatic fanout_t route_of(dir_e d, logic det_in,
                                         logic top_b, logic bot_b);
        fanout_t f;
        logic    edge_b;
        f      = '0;
        edge_b = top_b | bot_b;
        if (d == DIR_BELOW) begin
            f.links = '1;
        end else if (d == DIR_BAD) begin
            f = '0;
        end else if (!det_in) begin
            case (d)
                DIR_NW: begin
                    f = add_link(f, 1, 1'b0);
                    if (edge_b) f = add_link(f, 6, 1'b0);
                end
                DIR_N: begin
                    f = add_link(f, 1, 1'b1);
                    f = add_link(f, 2, 1'b0);
                    f = add_link(f, 3, 1'b1);
                end
                DIR_NE: begin
                    f = add_link(f, 3, 1'b0);
                    f = add_link(f, 4, 1'b1);
                end
                DIR_SE: begin
                    f = add_link(f, 4, 1'b0);
                    if (edge_b) f = add_link(f, 3, 1'b0);
                end
                DIR_S: begin
                    f = add_link(f, 4, 1'b1);
                    f = add_link(f, 5, 1'b0);
                    f = add_link(f, 6, 1'b1);
                end
                default: begin
                    f = add_link(f, 6, 1'b0);
                    f = add_link(f, 1, 1'b1);
                end
            endcase
        end else if (d == DIR_SE && top_b) begin
            f = add_link(f, 3, 1'b0);
        end else if (d == DIR_NW && bot_b) begin
            f = add_link(f, 1, 1'b1);
            f = add_link(f, 3, 1'b0);
            f = add_link(f, 4, 1'b0);
            f = add_link(f, 6, 1'b0);
        end else begin
            f = add_link(f, int'(d), 1'b1);
        end
        return f;
    endfunction

endpackage

// File: rtl/hexfwd_queue.sv
module hexfwd_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    input  logic         rd_en,
    output logic [W-1:0] head_word,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] slots [DEPTH];
    logic [AW:0]  wptr, rptr;
    logic         do_wr, do_rd;

    assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign empty = (wptr == rptr);
    assign do_wr = wr_en && !full && !clr;
    assign do_rd = rd_en && !empty && !clr;
    assign head_word = slots[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) slots[wptr[AW-1:0]] <= wr_word;
    end

endmodule

// File: rtl/hexfwd_route.sv
module hexfwd_route
    import hexfwd_pkg::*;
(
    input  logic [2:0]      dir_code,
    input  logic            det_in,
    input  logic            upper_b,
    input  logic            lower_b,
    output logic [NDIR-1:0] links,
    output logic [NDIR-1:0] link_det
);
    fanout_t fo;

    always_comb begin
        fo       = route_of(dir_e'(dir_code), det_in, upper_b, lower_b);
        links    = fo.links;
        link_det = fo.detour;
    end

endmodule

// File: rtl/hexfwd_tracker.sv
module hexfwd_tracker
    import hexfwd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            have_head,
    input  logic [NDIR-1:0] owed,
    input  logic [NDIR-1:0] ack,
    output logic [NDIR-1:0] req,
    output logic            release_head,
    output logic            any_owed
);
    logic [NDIR-1:0] served_q;
    logic [NDIR-1:0] served_now;
    logic [NDIR-1:0] left_after;

    assign req          = have_head ? (owed & ~served_q) : '0;
    assign served_now   = ack & req;
    assign left_after   = owed & ~(served_q | served_now);
    assign release_head = have_head && (left_after == '0) && !clr;
    assign any_owed     = |req;

    always_ff @(posedge clk) begin
        if (rst || clr || release_head) served_q <= '0;
        else                            served_q <= served_q | served_now;
    end

endmodule

// File: rtl/hexfwd_outbuf.sv
module hexfwd_outbuf
    import hexfwd_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ID_W   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [ID_W-1:0]   push_origin,
    input  logic [2:0]        push_dir,
    input  logic              push_detour,
    input  logic [DATA_W-1:0] push_data,
    input  logic              clear_q,
    input  logic              upper_border,
    input  logic              lower_border,
    input  logic [5:0]        send_ack,
    output logic              full,
    output logic              empty,
    output logic [5:0]        send_req,
    output logic [5:0]        send_detour,
    output logic [ID_W-1:0]   send_origin,
    output logic [DATA_W-1:0] send_data,
    output logic              pending
);
    localparam int PW = ID_W + 3 + 1 + DATA_W;

    logic [PW-1:0]     in_word, hd_word;
    logic [ID_W-1:0]   hd_origin;
    logic [2:0]        hd_dir;
    logic              hd_det;
    logic [DATA_W-1:0] hd_data;
    logic [NDIR-1:0]   owed_links, owed_det;
    logic              pop_w, empty_w;

    assign in_word = {push_origin, push_dir, push_detour, push_data};
    assign {hd_origin, hd_dir, hd_det, hd_data} = hd_word;

    hexfwd_queue #(.DEPTH(DEPTH), .W(PW)) u_queue (
        .clk(clk), .rst(rst), .clr(clear_q),
        .wr_en(push_valid), .wr_word(in_word),
        .rd_en(pop_w), .head_word(hd_word),
        .full(full), .empty(empty_w)
    );

    hexfwd_route u_route (
        .dir_code(hd_dir), .det_in(hd_det),
        .upper_b(upper_border), .lower_b(lower_border),
        .links(owed_links), .link_det(owed_det)
    );

    hexfwd_tracker u_track (
        .clk(clk), .rst(rst), .clr(clear_q),
        .have_head(!empty_w), .owed(owed_links), .ack(send_ack),
        .req(send_req), .release_head(pop_w), .any_owed(pending)
    );

    assign empty       = empty_w;
    assign send_detour = owed_det;
    assign send_origin = hd_origin;
    assign send_data   = hd_data;

endmodule

// File: rtl/hexfwd_outbuf_chk.sv
module hexfwd_outbuf_chk (
    input logic       clk,
    input logic       rst,
    input logic       push_valid,
    input logic       clear_q,
    input logic       full,
    input logic       empty,
    input logic       pop,
    input logic [5:0] send_req,
    input logic [5:0] send_ack
);
    a_r10_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> (send_req == 6'd0));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear_q |=> empty);

    a_r7_push_lands: assert property (@(posedge clk) disable iff (rst)
        (push_valid && empty && !clear_q) |=> !empty);

    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !clear_q) |=> full);

    for (genvar k = 0; k < 6; k++) begin : g_link
        a_r10_no_repeat: assert property (@(posedge clk) disable iff (rst)
            (send_req[k] && send_ack[k] && !pop && !clear_q) |=> !send_req[k]);
    end

endmodule

bind hexfwd_outbuf hexfwd_outbuf_chk u_chk (
    .clk(clk), .rst(rst), .push_valid(push_valid), .clear_q(clear_q),
    .full(full), .empty(empty), .pop(pop_w),
    .send_req(send_req), .send_ack(send_ack)
);

// File: tb/tb_hexfwd_outbuf.sv
module tb_hexfwd_outbuf;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [7:0]  push_origin = '0;
    logic [2:0]  push_dir = '0;
    logic        push_detour = 1'b0;
    logic [31:0] push_data = '0;
    logic        clear_q = 1'b0;
    logic        upper_border = 1'b0;
    logic        lower_border = 1'b0;
    logic [5:0]  send_ack = '0;
    logic        full, empty, pending;
    logic [5:0]  send_req, send_detour;
    logic [7:0]  send_origin;
    logic [31:0] send_data;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    bit [7:0]  m_org [DEPTH];
    bit [2:0]  m_dir [DEPTH];
    bit        m_det [DEPTH];
    bit [31:0] m_dat [DEPTH];
    int        m_head = 0;
    int        m_cnt = 0;
    bit [5:0]  m_done = '0;
    int        m_pops = 0;

    always #5 clk = ~clk;

    hexfwd_outbuf #(.DEPTH(DEPTH), .ID_W(8), .DATA_W(32)) dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_origin(push_origin),
        .push_dir(push_dir), .push_detour(push_detour), .push_data(push_data),
        .clear_q(clear_q), .upper_border(upper_border), .lower_border(lower_border),
        .send_ack(send_ack), .full(full), .empty(empty), .send_req(send_req),
        .send_detour(send_detour), .send_origin(send_origin), .send_data(send_data),
        .pending(pending)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected fan-out from the requirements; bit k = link k+1
    function automatic void exp_route(input int d, input bit dt, input bit up,
                                      input bit lo, output bit [5:0] m,
                                      output bit [5:0] x, output string tag);
        m = 0; x = 0;
        if (d == 0) begin m = 6'b111111; tag = "R1"; end
        else if (d == 7) begin tag = "R6"; end
        else if (!dt) begin
            tag = (d <= 3) ? "R2" : "R3";
            case (d)
                1: begin m = (up || lo) ? 6'b100001 : 6'b000001; end
                2: begin m = 6'b000111; x = 6'b000101; end
                3: begin m = 6'b001100; x = 6'b001000; end
                4: begin m = (up || lo) ? 6'b001100 : 6'b001000; end
                5: begin m = 6'b111000; x = 6'b101000; end
                default: begin m = 6'b100001; x = 6'b000001; end
            endcase
        end else if (d == 4 && up) begin m = 6'b000100; tag = "R5"; end
        else if (d == 1 && lo) begin m = 6'b101101; x = 6'b000001; tag = "R5"; end
        else begin m = 6'b1 << (d - 1); x = m; tag = "R4"; end
    endfunction

    // one cycle: check outputs against model, drive inputs, advance model
    task automatic cycle(input bit pv, input bit [2:0] pd, input bit pdt,
                         input bit [7:0] po, input bit [31:0] pdat,
                         input bit [5:0] ack, input bit clr);
        bit [5:0] m, x, req;
        string tag;
        bit pop;
        int tail;
        req = 0;
        check("R8 empty", empty, m_cnt == 0);
        check("R8 full", full, m_cnt == DEPTH);
        if (m_cnt > 0) begin
            exp_route(m_dir[m_head], m_det[m_head], upper_border, lower_border, m, x, tag);
            req = m & ~m_done;
            check({tag, " req"}, send_req, req);
            check({tag, " detour"}, send_detour & req, x & req);
            check("R7 origin", send_origin, m_org[m_head]);
            check("R7 data", send_data, m_dat[m_head]);
        end else begin
            m = 0;
            check("R10 idle req", send_req, 0);
        end
        check("R12 pending", pending, req != 0);
        push_valid = pv; push_dir = pd; push_detour = pdt;
        push_origin = po; push_data = pdat; send_ack = ack; clear_q = clr;
        pop  = (m_cnt > 0) && ((m & ~(m_done | (ack & req))) == 0) && !clr;
        tail = (m_head + m_cnt) % DEPTH;
        if (clr) begin
            m_cnt = 0; m_head = 0; m_done = 0;
        end else begin
            if (pv && m_cnt < DEPTH) begin
                m_org[tail] = po; m_dir[tail] = pd; m_det[tail] = pdt; m_dat[tail] = pdat;
                m_cnt++;
            end
            if (pop) begin
                m_head = (m_head + 1) % DEPTH; m_cnt--; m_done = 0; m_pops++;
            end else begin
                m_done |= ack & req;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int pops_before;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check("R8 reset empty", empty, 1);
        check("R8 reset full", full, 0);
        check("R10 reset req", send_req, 0);

        // R7: fill with code-2 packets, extra push while full is ignored
        for (int i = 0; i < DEPTH + 2; i++)
            cycle(1, 3'd2, 0, 8'(i + 1), 32'(i * 7), 6'd0, 0);
        check("R8 full after fill", full, 1);
        pops_before = m_pops;
        for (int i = 0; i < 3 * DEPTH; i++) cycle(0, 0, 0, 0, 0, 6'b111111, 0);
        check("R7 count drained", m_pops - pops_before, DEPTH);

        // R11: code-3 packet, link 3 first, then link 4 completes; next follows
        cycle(1, 3'd3, 0, 8'h31, 32'h11, 0, 0);
        cycle(1, 3'd5, 0, 8'h32, 32'h22, 0, 0);
        cycle(0, 0, 0, 0, 0, 6'b000100, 0);
        cycle(0, 0, 0, 0, 0, 6'b001000, 0);
        check("R11 next head", send_origin, 8'h32);
        check("R11 next req", send_req, 6'b111000);
        // R10: unrequested ack on link 1 ignored
        cycle(0, 0, 0, 0, 0, 6'b000001, 0);
        check("R10 stray ack", send_req, 6'b111000);
        cycle(0, 0, 0, 0, 0, 6'b111000, 0);

        // R9: clear wins over simultaneous push
        cycle(1, 3'd1, 0, 8'h41, 0, 0, 0);
        cycle(1, 3'd4, 1, 8'h42, 0, 0, 1);
        check("R9 cleared", empty, 1);
        check("R9 no req", send_req, 0);

        // R5 directed under each border
        upper_border = 1;
        cycle(1, 3'd4, 1, 8'h51, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0);
        check("R5 upper dir4", send_req, 6'b000100);
        cycle(0, 0, 0, 0, 0, 6'b111111, 0);
        upper_border = 0; lower_border = 1;
        cycle(1, 3'd1, 1, 8'h52, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0);
        check("R5 lower dir1", send_req, 6'b101101);
        cycle(0, 0, 0, 0, 0, 6'b111111, 0);
        lower_border = 0;

        // random phases over every border setting (R1..R12)
        for (int b = 0; b < 4; b++) begin
            // drain before changing the border inputs
            for (int i = 0; i < 3 * DEPTH; i++) cycle(0, 0, 0, 0, 0, 6'b111111, 0);
            upper_border = b[0]; lower_border = b[1];
            for (int i = 0; i < 600; i++)
                cycle(($urandom % 2) == 0, 3'($urandom % 8), 1'($urandom % 2),
                      8'($urandom), $urandom, 6'($urandom), ($urandom % 97) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule